// File: doc/BRIEF.md
# Sequence-Number Packet Placement Engine

This block takes packets that each carry a 16-bit sequence number and a payload of fixed length, and places every payload byte at the right address of a circular playout buffer. The buffer holds a power-of-two number of packet slots; a packet's slot is its sequence number modulo the slot count. The engine tracks the next sequence number it expects. Each arriving header is compared against that expectation and against the playout position supplied by the reader. The result picks one of five actions: start a new stream, write in order, fill a gap, reorder or discard.

When packets are missing, the engine writes one full payload of a configured conditioning byte for each missing sequence number before it writes the arriving payload. The number of bytes in the buffer therefore matches what the far end sent. A packet that arrives behind the expected number is written into its own slot if the reader has not reached that slot yet. Otherwise its payload is consumed and dropped. Three saturating counters report lost, reordered and discarded packets. The engine handles one packet at a time: it raises a header-ready signal when idle and a payload-ready signal while it accepts payload bytes.

Top module: `pkt_place_engine`

## Requirements
- R1: After reset, `hdr_ready_o` is 1, `pay_ready_o` and `wr_en_o` are 0, and all three counters read 0.
- R2: A header is taken on a cycle with `hdr_valid_i` and `hdr_ready_o` both high. `hdr_ready_o` then stays low until the last of the PAY_LEN payload bytes has been taken. `pay_ready_o` is never high while `hdr_ready_o` is high, and no write occurs while the engine is idle.
- R3: Byte k (counting from 0) of the packet with sequence s is written to address (s mod SLOTS)*PAY_LEN + k.
- R4: The first header after reset is written at its slot, and the expected number becomes its sequence plus 1.
- R5: If d = (seq − expected) mod 2^16 lies in 1..SLOTS−1, the engine first writes PAY_LEN bytes of `cond_byte_i` into each slot from expected to seq−1, in that order. It then writes the payload, adds d to the lost counter, and sets expected to seq+1.
- R6: If d lies in SLOTS..32767, the engine resynchronises: it writes no padding, leaves the lost counter unchanged, writes the payload, and sets expected to seq+1.
- R7: If d lies in 32768..65535 (the packet is behind), (seq − `play_seq_i`) mod 2^16 is below 32768, and (expected − seq) mod 2^16 ≤ SLOTS, then the payload is written into its slot (overwriting conditioning or older data), the reordered counter goes up by 1, and expected is unchanged.
- R8: Any other behind packet is discarded. Its PAY_LEN payload bytes are consumed with no write, the discarded counter goes up by 1, and expected is unchanged.
- R9: Each counter is CNT_W bits wide, never decreases, holds at 2^CNT_W − 1 instead of wrapping, and changes only in the cycle after a header is accepted.
- R10: Sequence numbers wrap modulo 2^16, so 0x0000 arriving when 0xFFFF was the last in-order packet counts as in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hdr_valid_i | input | 1 | Header present |
| hdr_seq_i | input | SEQ_W | Header sequence number |
| hdr_ready_o | output | 1 | Engine idle, header can be taken |
| pay_valid_i | input | 1 | Payload byte present |
| pay_data_i | input | 8 | Payload byte |
| pay_ready_o | output | 1 | Payload byte is taken this cycle if valid |
| play_seq_i | input | SEQ_W | Sequence number of the oldest slot not yet played out |
| cond_byte_i | input | 8 | Conditioning byte used for lost packets |
| wr_en_o | output | 1 | Buffer write strobe |
| wr_addr_o | output | ADDR_W | Buffer byte address |
| wr_data_o | output | 8 | Buffer write data |
| cnt_lost_o | output | CNT_W | Lost packets, saturating |
| cnt_reord_o | output | CNT_W | Reordered packets written, saturating |
| cnt_late_o | output | CNT_W | Discarded late packets, saturating |

## Verification
The assertions check the handshake rules every cycle: header-ready and payload-ready are never high together, nothing is written while idle, and padding writes carry the conditioning byte. They also check that the counters only rise and move only after an accepted header. Slot addresses, the number of padding bytes, the choice between reorder and discard against the playout position, resynchronisation on large jumps, sequence wrap and counter saturation depend on packet history. Only the directed scenarios can show these, by comparing a shadow copy of the buffer and the counters with values worked out by hand.

// File: rtl/pkt_place_pkg.sv
package pkt_place_pkg;
  typedef enum logic [2:0] {
    CLS_SYNC,
    CLS_INORD,
    CLS_GAP,
    CLS_REORD,
    CLS_LATE
  } pkt_cls_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PAD,
    ST_DATA
  } eng_st_e;
endpackage

// File: rtl/seq_classifier.sv
module seq_classifier
  import pkt_place_pkg::*;
#(
  parameter int SEQ_W = 16,
  parameter int SLOTS = 8
) (
  input  logic             synced_i,
  input  logic [SEQ_W-1:0] seq_i,
  input  logic [SEQ_W-1:0] exp_i,
  input  logic [SEQ_W-1:0] play_i,
  output pkt_cls_e         cls_o,
  output logic [SEQ_W-1:0] gap_o
);
  logic [SEQ_W-1:0] fwd, back, ahead_play;

  always_comb begin
    fwd        = seq_i - exp_i;
    back       = exp_i - seq_i;
    ahead_play = seq_i - play_i;
    gap_o      = fwd;
    if (!synced_i)                          cls_o = CLS_SYNC;
    else if (fwd == '0)                     cls_o = CLS_INORD;
    else if (!fwd[SEQ_W-1] && fwd < SEQ_W'(SLOTS)) cls_o = CLS_GAP;
    else if (!fwd[SEQ_W-1])                 cls_o = CLS_SYNC;
    else if (!ahead_play[SEQ_W-1] && back <= SEQ_W'(SLOTS)) cls_o = CLS_REORD;
    else                                    cls_o = CLS_LATE;
  end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int CNT_W = 8,
  parameter int AMT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int SUM_W = ((CNT_W > AMT_W) ? CNT_W : AMT_W) + 1;
  localparam logic [SUM_W-1:0] MAX_V = SUM_W'({CNT_W{1'b1}});

  logic [SUM_W-1:0] sum;
  assign sum = SUM_W'(cnt_o) + SUM_W'(amt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= (sum > MAX_V) ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
  end
endmodule

// File: rtl/slot_addr_gen.sv
module slot_addr_gen #(
  parameter int SLOT_W = 3,
  parameter int BYTE_W = 2,
  parameter int PAY_LEN = 4,
  parameter int ADDR_W = 5
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [31:0] full;
  assign full   = 32'(slot_i) * 32'(PAY_LEN) + 32'(byte_i);
  assign addr_o = full[ADDR_W-1:0];
endmodule

// File: rtl/pkt_place_engine.sv
module pkt_place_engine
  import pkt_place_pkg::*;
#(
  parameter int SEQ_W   = 16,
  parameter int SLOTS   = 8,
  parameter int PAY_LEN = 4,
  parameter int CNT_W   = 8,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int BYTE_W = (PAY_LEN > 1) ? $clog2(PAY_LEN) : 1,
  localparam int ADDR_W = $clog2(SLOTS * PAY_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hdr_valid_i,
  input  logic [SEQ_W-1:0]  hdr_seq_i,
  output logic              hdr_ready_o,
  input  logic              pay_valid_i,
  input  logic [7:0]        pay_data_i,
  output logic              pay_ready_o,
  input  logic [SEQ_W-1:0]  play_seq_i,
  input  logic [7:0]        cond_byte_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic [CNT_W-1:0]  cnt_lost_o,
  output logic [CNT_W-1:0]  cnt_reord_o,
  output logic [CNT_W-1:0]  cnt_late_o
);
  eng_st_e          st_q;
  logic             synced_q, drop_q;
  logic [SEQ_W-1:0] exp_q, cur_q, pkt_q;
  logic [SLOT_W-1:0] pad_left_q;
  logic [BYTE_W-1:0] byte_q;

  pkt_cls_e         cls;
  logic [SEQ_W-1:0] gap;
  logic             accept, last_byte;

  seq_classifier #(.SEQ_W(SEQ_W), .SLOTS(SLOTS)) u_cls (
    .synced_i(synced_q), .seq_i(hdr_seq_i), .exp_i(exp_q),
    .play_i(play_seq_i), .cls_o(cls), .gap_o(gap)
  );

  assign accept    = hdr_valid_i && hdr_ready_o;
  assign last_byte = (byte_q == BYTE_W'(PAY_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      synced_q   <= 1'b0;
      drop_q     <= 1'b0;
      exp_q      <= '0;
      cur_q      <= '0;
      pkt_q      <= '0;
      pad_left_q <= '0;
      byte_q     <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          synced_q <= 1'b1;
          byte_q   <= '0;
          pkt_q    <= hdr_seq_i;
          drop_q   <= (cls == CLS_LATE);
          if (cls == CLS_GAP) begin
            cur_q      <= exp_q;
            pad_left_q <= SLOT_W'(gap - 1'b1);
            st_q       <= ST_PAD;
          end else begin
            cur_q <= hdr_seq_i;
            st_q  <= ST_DATA;
          end
          if (cls == CLS_SYNC || cls == CLS_INORD || cls == CLS_GAP)
            exp_q <= hdr_seq_i + 1'b1;
        end
        ST_PAD: begin
          byte_q <= last_byte ? '0 : byte_q + 1'b1;
          if (last_byte) begin
            if (pad_left_q == '0) begin
              cur_q <= pkt_q;
              st_q  <= ST_DATA;
            end else begin
              pad_left_q <= pad_left_q - 1'b1;
              cur_q      <= cur_q + 1'b1;
            end
          end
        end
        ST_DATA: if (pay_valid_i) begin
          byte_q <= last_byte ? '0 : byte_q + 1'b1;
          if (last_byte) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign hdr_ready_o = (st_q == ST_IDLE);
  assign pay_ready_o = (st_q == ST_DATA);
  assign wr_en_o     = (st_q == ST_PAD) || (st_q == ST_DATA && pay_valid_i && !drop_q);
  assign wr_data_o   = (st_q == ST_PAD) ? cond_byte_i : pay_data_i;

  slot_addr_gen #(.SLOT_W(SLOT_W), .BYTE_W(BYTE_W), .PAY_LEN(PAY_LEN), .ADDR_W(ADDR_W)) u_addr (
    .slot_i(cur_q[SLOT_W-1:0]), .byte_i(byte_q), .addr_o(wr_addr_o)
  );

  // counter bank: lost adds the gap, the others add one
  logic [2:0]       cnt_inc;
  logic [SEQ_W-1:0] cnt_amt [3];
  logic [CNT_W-1:0] cnt_val [3];

  assign cnt_inc[0] = accept && (cls == CLS_GAP);
  assign cnt_inc[1] = accept && (cls == CLS_REORD);
  assign cnt_inc[2] = accept && (cls == CLS_LATE);
  assign cnt_amt[0] = gap;
  assign cnt_amt[1] = SEQ_W'(1);
  assign cnt_amt[2] = SEQ_W'(1);

  for (genvar g = 0; g < 3; g++) begin : g_cnt
    sat_counter #(.CNT_W(CNT_W), .AMT_W(SEQ_W)) u_sat (
      .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(cnt_inc[g]),
      .amt_i(cnt_amt[g]), .cnt_o(cnt_val[g])
    );
  end

  assign cnt_lost_o  = cnt_val[0];
  assign cnt_reord_o = cnt_val[1];
  assign cnt_late_o  = cnt_val[2];
endmodule

// File: rtl/pkt_place_engine_chk.sv
module pkt_place_engine_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hdr_valid_i,
  input logic             hdr_ready_o,
  input logic             pay_ready_o,
  input logic             wr_en_o,
  input logic [7:0]       wr_data_o,
  input logic [7:0]       cond_byte_i,
  input logic [CNT_W-1:0] cnt_lost_o,
  input logic [CNT_W-1:0] cnt_reord_o,
  input logic [CNT_W-1:0] cnt_late_o
);
  assert_ready_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_ready_o |-> !pay_ready_o);

  assert_busy_after_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_i && hdr_ready_o) |=> !hdr_ready_o);

  assert_no_idle_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_ready_o |-> !wr_en_o);

  assert_pad_uses_cond_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !pay_ready_o) |-> (wr_data_o == cond_byte_i));

  assert_lost_monotone_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_lost_o >= $past(cnt_lost_o));

  assert_reord_on_accept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_reord_o != $past(cnt_reord_o)) |-> $past(hdr_valid_i && hdr_ready_o));

  assert_late_on_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_late_o != $past(cnt_late_o)) |-> $past(hdr_valid_i && hdr_ready_o));
endmodule

bind pkt_place_engine pkt_place_engine_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hdr_valid_i(hdr_valid_i),
  .hdr_ready_o(hdr_ready_o), .pay_ready_o(pay_ready_o), .wr_en_o(wr_en_o),
  .wr_data_o(wr_data_o), .cond_byte_i(cond_byte_i), .cnt_lost_o(cnt_lost_o),
  .cnt_reord_o(cnt_reord_o), .cnt_late_o(cnt_late_o)
);

// File: tb/pkt_place_engine_bench.sv
`timescale 1ns/1ps
module pkt_place_engine_bench;
  localparam int SEQ_W = 16, SLOTS = 8, PAY_LEN = 4, CNT_W = 4;
  localparam int ADDR_W = 5;
  localparam logic [7:0] COND = 8'hA5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hdr_valid = 1'b0, pay_valid = 1'b0;
  logic [SEQ_W-1:0] hdr_seq = '0, play_seq = '0;
  logic [7:0] pay_data = '0;
  logic hdr_ready, pay_ready, wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0] wr_data;
  logic [CNT_W-1:0] c_lost, c_reord, c_late;

  int checks = 0, errors = 0, wr_cnt = 0;
  logic [7:0] mem [SLOTS*PAY_LEN];

  always #2.5 clk = ~clk;

  pkt_place_engine #(.SEQ_W(SEQ_W), .SLOTS(SLOTS), .PAY_LEN(PAY_LEN), .CNT_W(CNT_W)) u_pkt_place_engine (
    .clk_i(clk), .rst_ni(rst_n), .hdr_valid_i(hdr_valid), .hdr_seq_i(hdr_seq),
    .hdr_ready_o(hdr_ready), .pay_valid_i(pay_valid), .pay_data_i(pay_data),
    .pay_ready_o(pay_ready), .play_seq_i(play_seq), .cond_byte_i(COND),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .cnt_lost_o(c_lost), .cnt_reord_o(c_reord), .cnt_late_o(c_late)
  );

  always @(posedge clk) if (wr_en) begin
    mem[wr_addr] <= wr_data;
    wr_cnt <= wr_cnt + 1;
  end

  function automatic logic [7:0] pbyte(input logic [15:0] s, input int k);
    return {s[5:0], 2'(k)};
  endfunction

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic check_slot_pay(input string req, input logic [15:0] s);
    for (int k = 0; k < PAY_LEN; k++)
      check(req, mem[(int'(s) % SLOTS) * PAY_LEN + k], pbyte(s, k));
  endtask

  task automatic check_slot_cond(input string req, input logic [15:0] s);
    for (int k = 0; k < PAY_LEN; k++)
      check(req, mem[(int'(s) % SLOTS) * PAY_LEN + k], COND);
  endtask

  task automatic send(input logic [15:0] s, input bit chk_busy);
    int i;
    @(negedge clk);
    while (!hdr_ready) @(negedge clk);
    hdr_valid = 1'b1;
    hdr_seq = s;
    @(negedge clk);
    hdr_valid = 1'b0;
    if (chk_busy) check("R2 busy after header", int'(hdr_ready), 0);
    i = 0;
    while (i < PAY_LEN) begin
      pay_valid = 1'b1;
      pay_data = pbyte(s, i);
      if (pay_ready) i++;
      if (i < PAY_LEN) @(negedge clk);
    end
    @(negedge clk);
    pay_valid = 1'b0;
    while (!hdr_ready) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 hdr_ready", int'(hdr_ready), 1);
    check("R1 pay_ready", int'(pay_ready), 0);
    check("R1 wr_en", int'(wr_en), 0);
    check("R1 counters", int'(c_lost) + int'(c_reord) + int'(c_late), 0);
  endtask

  task automatic t_in_order;
    send(16'd100, 1'b1);
    send(16'd101, 1'b0);
    check_slot_pay("R4 first packet slot", 16'd100);
    check_slot_pay("R3 in-order slot", 16'd101);
    check("R3 write count", wr_cnt, 8);
    check("R4 no loss", int'(c_lost), 0);
  endtask

  task automatic t_gap;
    int w0 = wr_cnt;
    send(16'd104, 1'b1);
    check("R5 lost count", int'(c_lost), 2);
    check_slot_cond("R5 pad 102", 16'd102);
    check_slot_cond("R5 pad 103", 16'd103);
    check_slot_pay("R5 payload after pad", 16'd104);
    check("R5 write count", wr_cnt - w0, 12);
  endtask

  task automatic t_reorder;
    play_seq = 16'd101;
    send(16'd103, 1'b0);
    check("R7 reorder count", int'(c_reord), 1);
    check_slot_pay("R7 reorder overwrites pad", 16'd103);
  endtask

  task automatic t_late;
    int w0 = wr_cnt;
    play_seq = 16'd103;
    send(16'd102, 1'b0);
    check("R8 late count", int'(c_late), 1);
    check("R8 no write", wr_cnt - w0, 0);
    check_slot_cond("R8 slot untouched", 16'd102);
    check("R8 expected unchanged", int'(c_reord), 1);
    send(16'd105, 1'b0);
    check("R8 next in order no loss", int'(c_lost), 2);
  endtask

  task automatic t_resync;
    int w0 = wr_cnt;
    send(16'd200, 1'b0);
    check("R6 no loss on jump", int'(c_lost), 2);
    check("R6 no padding", wr_cnt - w0, 4);
    check_slot_pay("R6 payload slot", 16'd200);
    send(16'd201, 1'b0);
    check("R6 new expected", int'(c_lost), 2);
  endtask

  task automatic t_wrap;
    send(16'h70C9, 1'b0);
    send(16'hE0C9, 1'b0);
    send(16'hFFFF, 1'b0);
    check("R6 jumps no loss", int'(c_lost), 2);
    send(16'h0000, 1'b0);
    check("R10 wrap in order", int'(c_lost), 2);
    check_slot_pay("R10 slot 0", 16'h0000);
    send(16'h0002, 1'b0);
    check("R10 gap across wrap", int'(c_lost), 3);
    check_slot_cond("R10 pad 1", 16'h0001);
  endtask

  task automatic t_saturate;
    send(16'd10, 1'b0);
    check("R9 lost adds gap", int'(c_lost), 10);
    send(16'd18, 1'b0);
    check("R9 saturate", int'(c_lost), 15);
    send(16'd26, 1'b0);
    check("R9 hold max", int'(c_lost), 15);
  endtask

  initial begin
    for (int k = 0; k < SLOTS*PAY_LEN; k++) mem[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_in_order();
    t_gap();
    t_reorder();
    t_late();
    t_resync();
    t_wrap();
    t_saturate();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule